// File: doc/BRIEF.md
# Cross Trigger Event Router

This block routes debug events inside one debug cluster. Attached devices raise input trigger lines. Each line can be bound to any mix of four shared event channels. An active channel drives every output trigger line bound to it. It is also offered to an external channel matrix, channel by channel, through an outbound gate. Channel activity arriving from that matrix drives local output triggers in the same way. Software can also raise channels directly: it can hold a channel until cleared, or fire it for a single cycle.

A word-addressed register bus programs the block. It writes the binding masks, the set, clear and pulse strobes, the outbound gate, the global enable, and an output safety filter. The filter forces chosen outputs low, for example a halt request to a core. The same bus reads back the channel, output and input status. After reset nothing is bound and the global enable is off, so the block is inert until software programs it.

Register word addresses:
- 0x00 control: bit 0 is the global enable (reset 0), bit 1 is the filter enable (reset 1).
- 0x01 restore-defaults: writing bit 0 set returns every register to its reset value.
- 0x02 set, 0x03 clear and 0x04 pulse: channel bit masks.
- 0x05 outbound gate (reset 0xF).
- 0x06 filtered-output mask (reset `FILT_DEFAULT`, 0x01).
- 0x07, 0x08 and 0x09 (read-only): channel status, output status and input status.
- 0x10+i: input i binding mask. 0x20+j: output j binding mask.

Top module: `xtrig_unit`

## Requirements
- R1: After reset, trig_out and chan_out are 0. The control word reads 0x2, the gate reads 0xF, the filter mask reads 0x01 and every binding mask reads 0. With no bindings, active inputs leave all outputs low.
- R2: An input change at trig_in is synchronized by two flops. The output trigger bound through a channel changes after the third rising edge. Channel c active reads as bit c of status, so channel 2 reads 0x4.
- R3: A channel is active when any bound input, the set register, the pulse strobe or chan_in has that bit. An output is high when any channel in its binding mask is active.
- R4: chan_out is the locally sourced channel vector ANDed with the gate, registered one cycle. A gate write takes effect on chan_out one edge after the write.
- R5: A write to the set register holds the channels active until a write to the clear register removes them.
- R6: A write to the pulse register makes the channels active for exactly one cycle. The bound output is high for exactly one cycle.
- R7: While the filter enable is 1, every output whose bit is set in the filter mask stays low. Clearing the filter enable lets it through.
- R8: A restore-defaults write clears all bindings, the set register and the pulse strobe, and restores the gate, the control word and the filter mask to their reset values.
- R9: The output status register has one bit per output, so output 6 reads 0x40. The input status register shows the synchronized inputs.
- R10: While the global enable is 0, trig_out, chan_out and channel status are all 0 one cycle later.
- R11: Channels arriving on chan_in drive bound outputs but are never echoed back onto chan_out.
- R12: bus_ready is always 1. Each accepted read returns rsp_valid with data one cycle later, and no rsp_valid follows a write. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | N_IN | Input trigger lines, asynchronous |
| trig_out | output | N_OUT | Registered output trigger lines |
| chan_in | input | N_CH | Channel activity from the matrix |
| chan_out | output | N_CH | Gated channel activity to the matrix |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The bound checker watches several properties on every cycle:
- the reset values of the outputs;
- that gated-off channels never reach chan_out;
- that filtered outputs stay low while the filter is on;
- that everything is silent a cycle after the enable drops;
- the one-cycle read response.

Only the directed scenarios can show behaviour over several cycles. These are the three-edge input latency, set holding until clear, the single-cycle width of a pulse, OR-combining of channels, the suppressed echo of matrix channels, and the complete restore of defaults.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] A_RESTORE = 8'h01;
  localparam logic [ADDR_W-1:0] A_SET     = 8'h02;
  localparam logic [ADDR_W-1:0] A_CLR     = 8'h03;
  localparam logic [ADDR_W-1:0] A_PULSE   = 8'h04;
  localparam logic [ADDR_W-1:0] A_GATE    = 8'h05;
  localparam logic [ADDR_W-1:0] A_FMASK   = 8'h06;
  localparam logic [ADDR_W-1:0] A_CHST    = 8'h07;
  localparam logic [ADDR_W-1:0] A_OUTST   = 8'h08;
  localparam logic [ADDR_W-1:0] A_INST    = 8'h09;
  localparam logic [ADDR_W-1:0] A_IN_BASE  = 8'h10;
  localparam logic [ADDR_W-1:0] A_OUT_BASE = 8'h20;
  localparam int MAX_LINES = 16;
endpackage

// File: rtl/xtrig_sync.sv
module xtrig_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4,
  parameter logic [N_OUT-1:0] FILT_DEFAULT = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_valid,
  input  logic                         bus_write,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_rdata,
  input  logic [N_CH-1:0]              ch_status,
  input  logic [N_OUT-1:0]             out_status,
  input  logic [N_IN-1:0]              in_status,
  output logic                         glob_en,
  output logic                         filt_en,
  output logic [N_OUT-1:0]             filt_mask,
  output logic [N_CH-1:0]              gate,
  output logic [N_CH-1:0]              sw_set,
  output logic [N_CH-1:0]              sw_pulse,
  output logic [N_IN-1:0][N_CH-1:0]    in_att,
  output logic [N_OUT-1:0][N_CH-1:0]   out_att
);
  localparam logic [N_CH-1:0] GATE_DEFAULT = '1;

  logic              wr, rd, restore;
  logic [N_CH-1:0]   wch;
  logic [DATA_W-1:0] rdata_c;
  logic              unused_wdata;

  assign wr      = bus_valid && bus_write;
  assign rd      = bus_valid && !bus_write;
  assign wch     = bus_wdata[N_CH-1:0];
  assign restore = wr && (bus_addr == A_RESTORE) && bus_wdata[0];
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst || restore) begin
      glob_en   <= 1'b0;
      filt_en   <= 1'b1;
      filt_mask <= FILT_DEFAULT;
      gate      <= GATE_DEFAULT;
      sw_set    <= '0;
      sw_pulse  <= '0;
      in_att    <= '0;
      out_att   <= '0;
    end else begin
      sw_pulse <= (wr && bus_addr == A_PULSE) ? wch : '0;
      if (wr) begin
        if (bus_addr == A_CTRL) begin
          glob_en <= bus_wdata[0];
          filt_en <= bus_wdata[1];
        end
        if (bus_addr == A_SET)   sw_set    <= sw_set | wch;
        if (bus_addr == A_CLR)   sw_set    <= sw_set & ~wch;
        if (bus_addr == A_GATE)  gate      <= wch;
        if (bus_addr == A_FMASK) filt_mask <= bus_wdata[N_OUT-1:0];
        for (int i = 0; i < N_IN; i++) begin
          if (bus_addr == A_IN_BASE + ADDR_W'(i)) in_att[i] <= wch;
        end
        for (int j = 0; j < N_OUT; j++) begin
          if (bus_addr == A_OUT_BASE + ADDR_W'(j)) out_att[j] <= wch;
        end
      end
    end
  end

  always_comb begin
    rdata_c = '0;
    case (bus_addr)
      A_CTRL:  rdata_c = DATA_W'({filt_en, glob_en});
      A_GATE:  rdata_c = DATA_W'(gate);
      A_FMASK: rdata_c = DATA_W'(filt_mask);
      A_SET:   rdata_c = DATA_W'(sw_set);
      A_CHST:  rdata_c = DATA_W'(ch_status);
      A_OUTST: rdata_c = DATA_W'(out_status);
      A_INST:  rdata_c = DATA_W'(in_status);
      default: rdata_c = '0;
    endcase
    for (int i = 0; i < N_IN; i++) begin
      if (bus_addr == A_IN_BASE + ADDR_W'(i)) rdata_c = DATA_W'(in_att[i]);
    end
    for (int j = 0; j < N_OUT; j++) begin
      if (bus_addr == A_OUT_BASE + ADDR_W'(j)) rdata_c = DATA_W'(out_att[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rdata_c : '0;
    end
  end
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        glob_en,
  input  logic                        filt_en,
  input  logic [N_OUT-1:0]            filt_mask,
  input  logic [N_CH-1:0]             gate,
  input  logic [N_CH-1:0]             sw_set,
  input  logic [N_CH-1:0]             sw_pulse,
  input  logic [N_IN-1:0][N_CH-1:0]   in_att,
  input  logic [N_OUT-1:0][N_CH-1:0]  out_att,
  input  logic [N_IN-1:0]             trig_sync,
  input  logic [N_CH-1:0]             chan_in,
  output logic [N_CH-1:0]             ch_eff,
  output logic [N_OUT-1:0]            trig_out_q,
  output logic [N_CH-1:0]             chan_out_q
);
  logic [N_CH-1:0]  from_inputs;
  logic [N_CH-1:0]  local_ch;
  logic [N_OUT-1:0] out_raw;
  logic [N_OUT-1:0] blocked;

  always_comb begin
    from_inputs = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (trig_sync[i]) from_inputs = from_inputs | in_att[i];
    end
    local_ch = glob_en ? (sw_set | sw_pulse | from_inputs) : '0;
    ch_eff   = glob_en ? (local_ch | chan_in) : '0;
  end

  genvar j;
  generate
    for (j = 0; j < N_OUT; j++) begin : g_out
      assign out_raw[j] = |(out_att[j] & ch_eff);
    end
  endgenerate

  assign blocked = filt_en ? filt_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_out_q <= '0;
      chan_out_q <= '0;
    end else begin
      trig_out_q <= glob_en ? (out_raw & ~blocked) : '0;
      chan_out_q <= local_ch & gate;
    end
  end
endmodule

// File: rtl/xtrig_unit.sv
module xtrig_unit
  import xtrig_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4,
  parameter logic [N_OUT-1:0] FILT_DEFAULT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   trig_in,
  output logic [N_OUT-1:0]  trig_out,
  input  logic [N_CH-1:0]   chan_in,
  output logic [N_CH-1:0]   chan_out,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int SYNC_STAGES = 2;

  logic [N_IN-1:0]             trig_sync;
  logic                        glob_en, filt_en;
  logic [N_OUT-1:0]            filt_mask;
  logic [N_CH-1:0]             gate_mask, sw_set, sw_pulse, ch_eff;
  logic [N_IN-1:0][N_CH-1:0]   in_att;
  logic [N_OUT-1:0][N_CH-1:0]  out_att;

  assign bus_ready = 1'b1;

  xtrig_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(trig_in), .q(trig_sync)
  );

  xtrig_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH),
               .FILT_DEFAULT(FILT_DEFAULT)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ch_status(ch_eff), .out_status(trig_out), .in_status(trig_sync),
    .glob_en(glob_en), .filt_en(filt_en), .filt_mask(filt_mask),
    .gate(gate_mask), .sw_set(sw_set), .sw_pulse(sw_pulse),
    .in_att(in_att), .out_att(out_att)
  );

  xtrig_route #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH)) u_route (
    .clk(clk), .rst(rst),
    .glob_en(glob_en), .filt_en(filt_en), .filt_mask(filt_mask),
    .gate(gate_mask), .sw_set(sw_set), .sw_pulse(sw_pulse),
    .in_att(in_att), .out_att(out_att),
    .trig_sync(trig_sync), .chan_in(chan_in),
    .ch_eff(ch_eff), .trig_out_q(trig_out), .chan_out_q(chan_out)
  );
endmodule

// File: rtl/xtrig_unit_chk.sv
module xtrig_unit_chk #(
  parameter int N_OUT = 8,
  parameter int N_CH  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_write,
  input logic             rsp_valid,
  input logic [N_OUT-1:0] trig_out,
  input logic [N_CH-1:0]  chan_out,
  input logic             glob_en,
  input logic             filt_en,
  input logic [N_OUT-1:0] filt_mask,
  input logic [N_CH-1:0]  gate_mask
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (trig_out == '0 && chan_out == '0));

  // R4
  gate_block_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((chan_out & ~$past(gate_mask)) == '0));

  // R7
  filter_block_chk: assert property (@(posedge clk) disable iff (rst)
    filt_en |=> ((trig_out & $past(filt_mask)) == '0));

  // R10
  enable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> (trig_out == '0 && chan_out == '0));

  // R12
  read_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> rsp_valid);

  // R12
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> !rsp_valid);
endmodule

bind xtrig_unit xtrig_unit_chk #(.N_OUT(N_OUT), .N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .rsp_valid(rsp_valid), .trig_out(trig_out), .chan_out(chan_out),
  .glob_en(glob_en), .filt_en(filt_en), .filt_mask(filt_mask),
  .gate_mask(gate_mask)
);

// File: tb/tb_xtrig_unit.sv
module tb_xtrig_unit;
  localparam int N_IN = 8, N_OUT = 8, N_CH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0]  trig_in = '0;
  logic [N_OUT-1:0] trig_out;
  logic [N_CH-1:0]  chan_in = '0;
  logic [N_CH-1:0]  chan_out;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic bus_ready, rsp_valid;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, rsp_rdata;
  logic [31:0] rd;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xtrig_unit dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .trig_out(trig_out),
    .chan_in(chan_in), .chan_out(chan_out),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rdreg(logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1) begin
      failures++;
      $display("FAIL R12 rsp_valid actual=%b expected=1", rsp_valid);
    end
    d = rsp_rdata;
  endtask

  task automatic t_reset;
    chk("R1 trig_out", 32'(trig_out), 0);
    chk("R1 chan_out", 32'(chan_out), 0);
    rdreg(8'h00, rd); chk("R1 ctrl", rd, 32'h2);
    rdreg(8'h05, rd); chk("R1 gate", rd, 32'hF);
    rdreg(8'h06, rd); chk("R1 fmask", rd, 32'h1);
    rdreg(8'h13, rd); chk("R1 in attach", rd, 0);
    rdreg(8'h26, rd); chk("R1 out attach", rd, 0);
    wr(8'h00, 32'h3);
    trig_in = '1; step(4);
    chk("R1 unbound trig_out", 32'(trig_out), 0);
    chk("R1 unbound chan_out", 32'(chan_out), 0);
    rdreg(8'h09, rd); chk("R9 in status", rd, 32'hFF);
    trig_in = '0; step(3);
  endtask

  task automatic t_route;
    wr(8'h11, 32'h4); wr(8'h26, 32'h4);
    trig_in[1] = 1'b1;
    step(2); chk("R2 before third edge", 32'(trig_out), 0);
    step(1); chk("R2 trig_out", 32'(trig_out), 32'h40);
    chk("R2 chan_out", 32'(chan_out), 32'h4);
    rdreg(8'h07, rd); chk("R9 chan status", rd, 32'h4);
    rdreg(8'h08, rd); chk("R9 out status", rd, 32'h40);
    trig_in[1] = 1'b0; step(4);
    chk("R2 released", 32'(trig_out), 0);
  endtask

  task automatic t_multi;
    wr(8'h13, 32'h3); wr(8'h22, 32'h2); wr(8'h24, 32'h1);
    trig_in[3] = 1'b1; step(4);
    chk("R3 multi outputs", 32'(trig_out), 32'h14);
    chk("R3 multi chan_out", 32'(chan_out), 32'h3);
  endtask

  task automatic t_gate;
    wr(8'h05, 32'h1); step(1);
    chk("R4 gated chan_out", 32'(chan_out), 32'h1);
    chk("R4 outputs unaffected", 32'(trig_out), 32'h14);
    wr(8'h05, 32'hF); trig_in = '0; step(4);
    chk("R4 idle", 32'(chan_out), 0);
  endtask

  task automatic t_set_clear;
    wr(8'h25, 32'h8); wr(8'h02, 32'h8); step(1);
    chk("R5 set out", 32'(trig_out), 32'h20);
    chk("R5 set chan_out", 32'(chan_out), 32'h8);
    step(5); chk("R5 held", 32'(trig_out), 32'h20);
    wr(8'h03, 32'h8); step(1);
    chk("R5 cleared", 32'(trig_out), 0);
  endtask

  task automatic t_pulse;
    wr(8'h04, 32'h8);
    chk("R6 before", 32'(trig_out), 0);
    step(1); chk("R6 pulse high", 32'(trig_out), 32'h20);
    step(1); chk("R6 pulse gone", 32'(trig_out), 0);
  endtask

  task automatic t_filter;
    wr(8'h20, 32'h8); wr(8'h02, 32'h8); step(1);
    chk("R7 filtered", 32'(trig_out), 32'h20);
    wr(8'h00, 32'h1); step(1);
    chk("R7 filter off", 32'(trig_out), 32'h21);
    wr(8'h06, 32'h20); wr(8'h00, 32'h3); step(1);
    chk("R7 new mask", 32'(trig_out), 32'h01);
    wr(8'h06, 32'h1); wr(8'h03, 32'h8); step(1);
    chk("R7 cleared", 32'(trig_out), 0);
  endtask

  task automatic t_enable;
    wr(8'h02, 32'h8); step(1);
    chk("R10 on", 32'(trig_out), 32'h20);
    wr(8'h00, 32'h2); step(1);
    chk("R10 trig_out off", 32'(trig_out), 0);
    chk("R10 chan_out off", 32'(chan_out), 0);
    rdreg(8'h07, rd); chk("R10 chan status", rd, 0);
    wr(8'h00, 32'h3); step(1);
    chk("R10 back on", 32'(trig_out), 32'h20);
    wr(8'h03, 32'h8); step(1);
  endtask

  task automatic t_inbound;
    wr(8'h27, 32'h2);
    chan_in = 4'h2; step(1);
    chk("R11 inbound drives", 32'(trig_out), 32'h84);
    chk("R11 no echo", 32'(chan_out), 0);
    chan_in = '0; step(1);
    chk("R11 released", 32'(trig_out), 0);
  endtask

  task automatic t_restore;
    wr(8'h02, 32'h1); wr(8'h05, 32'h3); wr(8'h06, 32'hF0);
    wr(8'h01, 32'h1); step(1);
    chk("R8 outputs", 32'(trig_out), 0);
    rdreg(8'h11, rd); chk("R8 in attach", rd, 0);
    rdreg(8'h26, rd); chk("R8 out attach", rd, 0);
    rdreg(8'h02, rd); chk("R8 set reg", rd, 0);
    rdreg(8'h05, rd); chk("R8 gate", rd, 32'hF);
    rdreg(8'h00, rd); chk("R8 ctrl", rd, 32'h2);
    rdreg(8'h06, rd); chk("R8 fmask", rd, 32'h1);
  endtask

  task automatic t_bus;
    chk("R12 ready", 32'(bus_ready), 1);
    rdreg(8'h3F, rd); chk("R12 unmapped", rd, 0);
    wr(8'h05, 32'hF);
    chk("R12 no rsp after write", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_route();
    t_multi();
    t_gate();
    t_set_clear();
    t_pulse();
    t_filter();
    t_enable();
    t_inbound();
    t_restore();
    t_bus();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule